// File: doc/BRIEF.md
# Split-Mode Auto-Reload Timer

This block is an up-counting timer built from two byte registers, a low byte and a high byte. Software can write each byte on its own and read both at any time. A mode input chooses how the two bytes work. With the mode cleared they form one 16-bit counter. When that counter passes its top value it loads itself from a 16-bit reload value. With the mode set they act as two separate 8-bit counters, and each reloads from its own reload byte.

Counting advances only on a tick while the run input is high. The tick has three possible sources: every system clock cycle, every twelfth system clock cycle, or every eighth rising edge of an external clock. The external clock is first brought into the system clock domain through a synchronizer. Both dividers issue single-cycle enables, so all state runs on the system clock. The block records each wrap in a sticky per-byte flag and combines the flags with enable inputs to form an interrupt request.

Top module: `reload_timer`

## Requirements
- R1: After reset, both count bytes, both reload bytes, both flags and `irq` are 0.
- R2: `src_sel` encodes the tick source: 2'b00 gives a tick every system clock cycle, 2'b01 divides by 12, 2'b10 uses the external clock divided by 8, and 2'b11 gives no tick, so the count holds.
- R3: With `src_sel`=2'b01, the first advance comes on the 12th rising clock edge after `run` rises, and later advances come every 12 edges.
- R4: With `src_sel`=2'b10, every 8th rising edge of `ext_clk`, counted from the cycle `run` rises, advances the count by one after a two-stage synchronizer. Without `ext_clk` edges there is no advance.
- R5: While `run` is 0 the counter holds its value, and both dividers restart from zero.
- R6: In 16-bit mode (`split`=0), a tick at {hi,lo}=0xFFFF loads {`rld_hi`,`rld_lo`} and sets `flag_hi`.
- R7: In 16-bit mode, a tick at lo=0xFF sets `flag_lo` and carries into the high byte. If the high byte is not 0xFF the low byte becomes 0x00.
- R8: In split mode (`split`=1), each byte advances on every tick. A byte at 0xFF loads its own reload byte, and the low byte sets `flag_lo` while the high byte sets `flag_hi`.
- R9: The flags are sticky. A `wr_flags` write with `wdata[0]`=0 clears `flag_lo` and with `wdata[1]`=0 clears `flag_hi`. A 1 bit leaves its flag unchanged, and a set event in the same cycle wins over a clear.
- R10: `irq` = `irq_en` & (`flag_hi` | (`flag_lo` & (`split` | `lo_irq_en`))).
- R11: A write to a count byte loads `wdata` into that byte on the next edge, and neither byte advances in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | External clock, asynchronous to clk |
| run | input | 1 | Counting enable |
| split | input | 1 | 0: one 16-bit counter, 1: two 8-bit counters |
| src_sel | input | 2 | Tick source select |
| irq_en | input | 1 | Global interrupt enable |
| lo_irq_en | input | 1 | Low-byte interrupt enable in 16-bit mode |
| wdata | input | 8 | Write data for all register writes |
| wr_lo | input | 1 | Write low count byte |
| wr_hi | input | 1 | Write high count byte |
| wr_rld_lo | input | 1 | Write low reload byte |
| wr_rld_hi | input | 1 | Write high reload byte |
| wr_flags | input | 1 | Flag clear write (bit 0 low, bit 1 high) |
| cnt_lo | output | 8 | Low count byte |
| cnt_hi | output | 8 | High count byte |
| rld_lo | output | 8 | Low reload byte |
| rld_hi | output | 8 | High reload byte |
| flag_lo | output | 1 | Low-byte overflow flag |
| flag_hi | output | 1 | High-byte overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: 8-bit bytes, a divide-by-12 system prescaler, a divide-by-8 external prescaler and two synchronizer stages. The bytes are only 8 bits wide, so counts can be preloaded next to 0xFF and 0xFFFF, and every wrap, reload and carry is reached in one or two ticks. The small divider ratios put the exact 12-edge phase and the 8-edge external grouping within a few dozen cycles. The bench checks the exact edge of the first divided advance, and it confirms that nothing advances when no external edge arrives.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic [1:0] {
    SRC_SYS = 2'b00,
    SRC_DIV = 2'b01,
    SRC_EXT = 2'b10,
    SRC_OFF = 2'b11
  } tick_src_e;
endpackage

// File: rtl/tick_gen.sv
module tick_gen
  import timer_pkg::*;
#(
  parameter int SYS_DIV     = 12,
  parameter int EXT_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] src_sel,
  input  logic       ext_clk,
  output logic       tick
);
  localparam int SD_W = $clog2(SYS_DIV);
  localparam int ED_W = $clog2(EXT_DIV);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [SD_W-1:0]        div_q, div_d;
  logic [ED_W-1:0]        ext_q, ext_d;
  logic                   ext_edge;
  tick_src_e              src;

  assign src      = tick_src_e'(src_sel);
  assign ext_edge = sync_q[SYNC_STAGES-1] & ~prev_q;

  // next state of both prescalers; cleared while stopped or not selected
  always_comb begin
    div_d = '0;
    ext_d = '0;
    if (run && src == SRC_DIV && div_q != SD_W'(SYS_DIV - 1))
      div_d = div_q + 1'b1;
    if (run && src == SRC_EXT) begin
      if (!ext_edge)                        ext_d = ext_q;
      else if (ext_q != ED_W'(EXT_DIV - 1)) ext_d = ext_q + 1'b1;
    end
  end

  always_comb begin
    unique case (src)
      SRC_SYS: tick = run;
      SRC_DIV: tick = run && div_q == SD_W'(SYS_DIV - 1);
      SRC_EXT: tick = run && ext_edge && ext_q == ED_W'(EXT_DIV - 1);
      default: tick = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      div_q  <= '0;
      ext_q  <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk};
      prev_q <= sync_q[SYNC_STAGES-1];
      div_q  <= div_d;
      ext_q  <= ext_d;
    end
  end
endmodule

// File: rtl/count_core.sv
module count_core #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              split,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_rld_lo,
  input  logic              wr_rld_hi,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic [BYTE_W-1:0] cnt_hi,
  output logic [BYTE_W-1:0] rld_lo,
  output logic [BYTE_W-1:0] rld_hi,
  output logic              wrap_lo,
  output logic              wrap_hi
);
  localparam logic [BYTE_W-1:0] TOP = '1;

  logic [BYTE_W-1:0] lo_q, hi_q, rl_q, rh_q;
  logic [BYTE_W-1:0] lo_d, hi_d, rl_d, rh_d;
  logic              adv;

  assign adv     = tick & ~(wr_lo | wr_hi);
  assign wrap_lo = adv && lo_q == TOP;
  assign wrap_hi = split ? (adv && hi_q == TOP) : (wrap_lo && hi_q == TOP);

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    rl_d = wr_rld_lo ? wdata : rl_q;
    rh_d = wr_rld_hi ? wdata : rh_q;
    if (wr_lo) lo_d = wdata;
    if (wr_hi) hi_d = wdata;
    if (adv) begin
      if (split) begin
        lo_d = wrap_lo ? rl_q : lo_q + 1'b1;
        hi_d = wrap_hi ? rh_q : hi_q + 1'b1;
      end else if (wrap_hi) begin
        lo_d = rl_q;
        hi_d = rh_q;
      end else begin
        lo_d = lo_q + 1'b1;
        if (wrap_lo) hi_d = hi_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
      rl_q <= '0;
      rh_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
      rl_q <= rl_d;
      rh_q <= rh_d;
    end
  end

  assign cnt_lo = lo_q;
  assign cnt_hi = hi_q;
  assign rld_lo = rl_q;
  assign rld_hi = rh_q;
endmodule

// File: rtl/flag_ctl.sv
module flag_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_lo,
  input  logic       set_hi,
  input  logic       wr_flags,
  input  logic [1:0] keep_mask,
  input  logic       split,
  input  logic       irq_en,
  input  logic       lo_irq_en,
  output logic       flag_lo,
  output logic       flag_hi,
  output logic       irq
);
  logic lo_q, hi_q, lo_d, hi_d;

  // a set event takes precedence over a software clear
  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (wr_flags) begin
      lo_d = lo_q & keep_mask[0];
      hi_d = hi_q & keep_mask[1];
    end
    if (set_lo) lo_d = 1'b1;
    if (set_hi) hi_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= 1'b0;
      hi_q <= 1'b0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign flag_lo = lo_q;
  assign flag_hi = hi_q;
  assign irq     = irq_en & (hi_q | (lo_q & (split | lo_irq_en)));
endmodule

// File: rtl/reload_timer.sv
module reload_timer #(
  parameter int BYTE_W      = 8,
  parameter int SYS_DIV     = 12,
  parameter int EXT_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk,
  input  logic              run,
  input  logic              split,
  input  logic [1:0]        src_sel,
  input  logic              irq_en,
  input  logic              lo_irq_en,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_rld_lo,
  input  logic              wr_rld_hi,
  input  logic              wr_flags,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic [BYTE_W-1:0] cnt_hi,
  output logic [BYTE_W-1:0] rld_lo,
  output logic [BYTE_W-1:0] rld_hi,
  output logic              flag_lo,
  output logic              flag_hi,
  output logic              irq
);
  logic tick, set_lo, set_hi;

  tick_gen #(
    .SYS_DIV(SYS_DIV), .EXT_DIV(EXT_DIV), .SYNC_STAGES(SYNC_STAGES)
  ) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .src_sel(src_sel),
    .ext_clk(ext_clk), .tick(tick)
  );

  count_core #(.BYTE_W(BYTE_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .split(split), .wdata(wdata),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_rld_lo(wr_rld_lo), .wr_rld_hi(wr_rld_hi),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .rld_lo(rld_lo), .rld_hi(rld_hi),
    .wrap_lo(set_lo), .wrap_hi(set_hi)
  );

  flag_ctl u_flags (
    .clk(clk), .rst_n(rst_n), .set_lo(set_lo), .set_hi(set_hi),
    .wr_flags(wr_flags), .keep_mask(wdata[1:0]), .split(split),
    .irq_en(irq_en), .lo_irq_en(lo_irq_en),
    .flag_lo(flag_lo), .flag_hi(flag_hi), .irq(irq)
  );
endmodule

// File: rtl/reload_timer_chk.sv
module reload_timer_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              split,
  input logic              irq_en,
  input logic              tick,
  input logic [BYTE_W-1:0] wdata,
  input logic              wr_lo,
  input logic              wr_hi,
  input logic              wr_rld_lo,
  input logic              wr_rld_hi,
  input logic              wr_flags,
  input logic [BYTE_W-1:0] cnt_lo,
  input logic [BYTE_W-1:0] cnt_hi,
  input logic [BYTE_W-1:0] rld_lo,
  input logic [BYTE_W-1:0] rld_hi,
  input logic              flag_lo,
  input logic              flag_hi,
  input logic              irq
);
  localparam logic [BYTE_W-1:0] TOP = '1;

  p_hold_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !wr_lo && !wr_hi |=> $stable(cnt_lo) && $stable(cnt_hi));

  p_reload16_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !split && !wr_lo && !wr_hi && !wr_rld_lo && !wr_rld_hi &&
    cnt_lo == TOP && cnt_hi == TOP
    |=> cnt_lo == $past(rld_lo) && cnt_hi == $past(rld_hi) && flag_hi);

  p_split_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick && split && !wr_lo && !wr_hi && !wr_rld_lo && cnt_lo == TOP
    |=> cnt_lo == $past(rld_lo) && flag_lo);

  p_sticky_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_hi && !wr_flags |=> flag_hi);

  p_sticky_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_lo && !wr_flags |=> flag_lo);

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  p_byte_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> cnt_lo == $past(wdata));
endmodule

bind reload_timer reload_timer_chk #(.BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/test_reload_timer.sv
module test_reload_timer;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    string      tag;
    logic [7:0] lo;
    logic [7:0] hi;
    logic       fl;
    logic       fh;
    logic       ir;
  } exp_t;

  logic clk, rst_n, ext_clk, run, split, irq_en, lo_irq_en;
  logic [1:0] src_sel;
  logic [7:0] wdata, cnt_lo, cnt_hi, rld_lo, rld_hi;
  logic wr_lo, wr_hi, wr_rld_lo, wr_rld_hi, wr_flags;
  logic flag_lo, flag_hi, irq;

  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;
  exp_t sb_q[$];

  reload_timer i_reload_timer (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .run(run), .split(split),
    .src_sel(src_sel), .irq_en(irq_en), .lo_irq_en(lo_irq_en), .wdata(wdata),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_rld_lo(wr_rld_lo), .wr_rld_hi(wr_rld_hi),
    .wr_flags(wr_flags), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .rld_lo(rld_lo),
    .rld_hi(rld_hi), .flag_lo(flag_lo), .flag_hi(flag_hi), .irq(irq)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  // monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      wait (sb_q.size() != 0);
      #1;
      begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (cnt_lo !== e.lo || cnt_hi !== e.hi || flag_lo !== e.fl ||
            flag_hi !== e.fh || irq !== e.ir) begin
          errors++;
          $display("FAIL %s: got lo=%h hi=%h fl=%b fh=%b irq=%b, expected lo=%h hi=%h fl=%b fh=%b irq=%b",
                   e.tag, cnt_lo, cnt_hi, flag_lo, flag_hi, irq,
                   e.lo, e.hi, e.fl, e.fh, e.ir);
        end
      end
    end
  end

  task automatic expect_state(input string tag, input logic [7:0] lo, input logic [7:0] hi,
                              input logic fl, input logic fh, input logic ir);
    exp_t e;
    e.tag = tag; e.lo = lo; e.hi = hi; e.fl = fl; e.fh = fh; e.ir = ir;
    sb_q.push_back(e);
    wait (sb_q.size() == 0);
    #1;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // 0 lo, 1 hi, 2 reload lo, 3 reload hi, 4 flags
  task automatic write_reg(input int sel, input logic [7:0] d);
    wdata = d;
    case (sel)
      0: wr_lo = 1'b1;
      1: wr_hi = 1'b1;
      2: wr_rld_lo = 1'b1;
      3: wr_rld_hi = 1'b1;
      default: wr_flags = 1'b1;
    endcase
    step(1);
    {wr_lo, wr_hi, wr_rld_lo, wr_rld_hi, wr_flags} = '0;
  endtask

  task automatic ext_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ext_clk = 1'b1;
      step(2);
      ext_clk = 1'b0;
      step(2);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ext_clk = 1'b0; run = 1'b0; split = 1'b0; src_sel = 2'b00;
    irq_en = 1'b0; lo_irq_en = 1'b0; wdata = '0;
    {wr_lo, wr_hi, wr_rld_lo, wr_rld_hi, wr_flags} = '0;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    expect_state("R1 reset", 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    checks++;
    if (rld_lo !== 8'h00 || rld_hi !== 8'h00) begin
      errors++;
      $display("FAIL R1 reload: got %h%h, expected 0000", rld_hi, rld_lo);
    end

    // R6/R7: 16-bit wrap with reload
    write_reg(2, 8'h34);
    write_reg(3, 8'h12);
    write_reg(0, 8'hFE);
    write_reg(1, 8'hFF);
    run = 1'b1;
    step(1);
    expect_state("R2 sysclk tick", 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0);
    step(1);
    expect_state("R6 reload 16-bit", 8'h34, 8'h12, 1'b1, 1'b1, 1'b0);
    run = 1'b0;
    step(3);
    expect_state("R5 hold when stopped", 8'h34, 8'h12, 1'b1, 1'b1, 1'b0);

    // R7 carry from low byte
    write_reg(4, 8'h00);
    write_reg(0, 8'hFF);
    write_reg(1, 8'h05);
    run = 1'b1;
    step(1);
    run = 1'b0;
    expect_state("R7 low wrap carry", 8'h00, 8'h06, 1'b1, 1'b0, 1'b0);

    // R11 write suppresses counting in that cycle
    run = 1'b1;
    write_reg(0, 8'h80);
    expect_state("R11 write wins", 8'h80, 8'h06, 1'b1, 1'b0, 1'b0);
    step(1);
    run = 1'b0;
    expect_state("R11 counting resumes", 8'h81, 8'h06, 1'b1, 1'b0, 1'b0);

    // R9 set wins over a same-cycle clear
    write_reg(4, 8'h00);
    write_reg(0, 8'hFF);
    run = 1'b1;
    write_reg(4, 8'h00);
    run = 1'b0;
    expect_state("R9 set beats clear", 8'h00, 8'h07, 1'b1, 1'b0, 1'b0);
    write_reg(4, 8'h00);
    expect_state("R9 clear by zero", 8'h00, 8'h07, 1'b0, 1'b0, 1'b0);
    write_reg(4, 8'h03);
    expect_state("R9 one bits do not set", 8'h00, 8'h07, 1'b0, 1'b0, 1'b0);

    // R10 interrupt combination
    write_reg(0, 8'hFF);
    run = 1'b1;
    step(1);
    run = 1'b0;
    irq_en = 1'b1;
    expect_state("R10 low flag without low enable", 8'h00, 8'h08, 1'b1, 1'b0, 1'b0);
    lo_irq_en = 1'b1;
    expect_state("R10 low flag with low enable", 8'h00, 8'h08, 1'b1, 1'b0, 1'b1);
    lo_irq_en = 1'b0;
    split = 1'b1;
    expect_state("R10 split low flag", 8'h00, 8'h08, 1'b1, 1'b0, 1'b1);
    irq_en = 1'b0;
    expect_state("R10 global enable off", 8'h00, 8'h08, 1'b1, 1'b0, 1'b0);

    // R8 split mode, independent reloads
    write_reg(4, 8'h00);
    write_reg(2, 8'h10);
    write_reg(3, 8'h20);
    write_reg(0, 8'hFF);
    write_reg(1, 8'hFE);
    run = 1'b1;
    step(1);
    expect_state("R8 split low reload", 8'h10, 8'hFF, 1'b1, 1'b0, 1'b0);
    step(1);
    run = 1'b0;
    expect_state("R8 split high reload", 8'h11, 8'h20, 1'b1, 1'b1, 1'b0);

    // R3 divide by 12
    split = 1'b0;
    write_reg(4, 8'h00);
    write_reg(0, 8'h00);
    write_reg(1, 8'h00);
    src_sel = 2'b01;
    run = 1'b1;
    step(11);
    expect_state("R3 no advance before 12th edge", 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    step(1);
    expect_state("R3 advance on 12th edge", 8'h01, 8'h00, 1'b0, 1'b0, 1'b0);
    step(12);
    run = 1'b0;
    expect_state("R3 second advance", 8'h02, 8'h00, 1'b0, 1'b0, 1'b0);

    // R4 external clock divided by 8
    write_reg(0, 8'h00);
    src_sel = 2'b10;
    run = 1'b1;
    step(2);
    ext_pulses(16);
    step(6);
    expect_state("R4 sixteen edges give two", 8'h02, 8'h00, 1'b0, 1'b0, 1'b0);
    step(8);
    expect_state("R4 no edges no advance", 8'h02, 8'h00, 1'b0, 1'b0, 1'b0);

    // R2 code 11 gives no tick
    src_sel = 2'b11;
    step(5);
    run = 1'b0;
    expect_state("R2 source off", 8'h02, 8'h00, 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule